// File: doc/BRIEF.md
# Path Trace Monitor

This block watches the stream of path trace bytes that arrives once per frame and groups them into traces. Depending on the selected mode, a trace is either a fixed window of programmable length (1 to 64 bytes) or a window aligned by framing markers inside the bytes. One format ends each 64-byte trace with a carriage return and line feed pair. The other starts each 16-byte trace with the only byte that has its top bit set. At the end of every trace the block compares the trace with a reference. It raises or clears a mismatch flag and keeps the relevant trace in a small two-bank RAM that the host can read combinationally.

Five modes are available. The cyclic mode uses the previous trace as its reference. The fixed-reference mode uses bytes that the host has written. The two framing modes align the trace first and then compare it with the host's reference. The persistence mode accepts a new trace as the stored one only after it has repeated without change over a programmable number of consecutive traces. In that mode mismatch means "differs from the accepted trace". The configuration inputs are held stable while the block runs. Reset is applied whenever they change.

Top module: `path_trace_monitor`

## Requirements
- R1: In modes 0, 1 and 4, a trace is `cfg_len` bytes long. A value of 0 counts as 1 and values above 64 count as 64. `trace_end_o` pulses for one cycle in the cycle after the last byte of each trace is accepted.
- R2: Mode code 0, and the unused codes 5 to 7, compare each trace with the trace received just before it. The first trace after reset never raises the mismatch flag.
- R3: In mode 1, byte i of a trace is compared with the reference byte that the host wrote to address i through `ref_we`/`ref_addr`/`ref_wdata`.
- R4: Mode 2 ignores bytes until the first 0x0D byte that is directly followed by 0x0A. After that, each trace ends on its 64th byte or on a 0x0A that follows 0x0D, whichever comes first. A trace that does not end with 0x0D,0x0A in positions 62 and 63 is a mismatch. Position i is compared with reference address i.
- R5: Mode 3 ignores bytes until one with bit 7 set arrives. Such a byte always begins a 16-byte trace at position 0. If it arrives while a trace is partly received, the partial trace ends at once as a mismatch with a `trace_end_o` pulse. Position i is compared with reference address i.
- R6: Mode 4 accepts a trace once it has arrived identical N times in a row, where N is `cfg_persist`, or 1 when that input is 0. Until the first acceptance, `trace_valid_o` and `mismatch_o` stay 0. After that, mismatch means the trace differs from the accepted one. On acceptance the mismatch flag clears.
- R7: `mismatch_o` is set at the end of a trace that differs from its reference and cleared at the end of one that matches. It changes only together with a `trace_end_o` pulse.
- R8: `rd_data` shows, with no clock delay, byte `rd_addr` of the stored trace. In modes 0 to 3 this is the most recently received trace. In mode 4 it is the accepted trace.
- R9: After reset, `trace_end_o`, `mismatch_o` and `trace_valid_o` are 0.
- R10: A cycle with `in_valid` low has no effect, whatever `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Mode: 0 cyclic, 1 fixed reference, 2 CR/LF framing, 3 top-bit framing, 4 persistence |
| cfg_len | input | 7 | Trace length for modes 0, 1 and 4 |
| cfg_persist | input | 3 | Repetitions needed for acceptance in mode 4 |
| in_valid | input | 1 | `in_byte` carries a trace byte this cycle |
| in_byte | input | 8 | Received trace byte |
| ref_we | input | 1 | Host write strobe for the reference RAM |
| ref_addr | input | 6 | Reference write address |
| ref_wdata | input | 8 | Reference write data |
| rd_addr | input | 6 | Stored-trace read address |
| rd_data | output | 8 | Stored-trace byte at `rd_addr` |
| trace_end_o | output | 1 | One-cycle pulse at the end of each trace |
| mismatch_o | output | 1 | Last completed trace differed from its reference |
| trace_valid_o | output | 1 | A stored trace exists |

## Verification
The bench builds the block with its default parameters: 64-entry banks, a 16-byte top-bit frame and a 3-bit repetition count. With these values it can run a full 64-byte CR/LF trace and the clamped length values 0 and 100. It can also sweep every repetition setting from 0 to 7, and in each setting it breaks a run of identical traces one short of acceptance. In the fixed-reference mode it corrupts every position of an 8-byte trace in turn. In the top-bit mode it sends a framing byte in the middle of a trace.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [2:0] {
        MODE_CYCLIC  = 3'd0,
        MODE_FIXED   = 3'd1,
        MODE_CRLF    = 3'd2,
        MODE_TOPBIT  = 3'd3,
        MODE_PERSIST = 3'd4
    } ptm_mode_e;

    localparam logic [7:0] BYTE_CR = 8'h0D;
    localparam logic [7:0] BYTE_LF = 8'h0A;

    function automatic ptm_mode_e ptm_decode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_FIXED;
            3'd2:    return MODE_CRLF;
            3'd3:    return MODE_TOPBIT;
            3'd4:    return MODE_PERSIST;
            default: return MODE_CYCLIC;
        endcase
    endfunction

endpackage

// File: rtl/ptm_framer.sv
module ptm_framer
    import ptm_pkg::*;
#(
    parameter int MAX_LEN  = 64,
    parameter int CRLF_LEN = 64,
    parameter int TOP_LEN  = 16,
    localparam int POS_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ptm_mode_e        mode,
    input  logic [LEN_W-1:0] len_eff,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             take,
    output logic [POS_W-1:0] pos,
    output logic             last,
    output logic             bad,
    output logic             abort
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             locked;
        logic             prev_cr;
    } fr_state_t;

    fr_state_t fr_q, fr_d;
    logic      pair_end;

    always_comb begin
        fr_d     = fr_q;
        take     = 1'b0;
        last     = 1'b0;
        bad      = 1'b0;
        abort    = 1'b0;
        pos      = fr_q.pos;
        pair_end = fr_q.prev_cr && (in_byte == BYTE_LF);
        if (in_valid) begin
            fr_d.prev_cr = (in_byte == BYTE_CR);
            case (mode)
                MODE_CRLF: begin
                    if (!fr_q.locked) begin
                        if (pair_end) begin
                            fr_d.locked = 1'b1;
                            fr_d.pos    = '0;
                        end
                    end else begin
                        take     = 1'b1;
                        last     = pair_end || (fr_q.pos == POS_W'(CRLF_LEN - 1));
                        bad      = last && !(pair_end && (fr_q.pos == POS_W'(CRLF_LEN - 1)));
                        fr_d.pos = last ? '0 : fr_q.pos + POS_W'(1);
                    end
                end
                MODE_TOPBIT: begin
                    if (in_byte[7]) begin
                        take        = 1'b1;
                        pos         = '0;
                        abort       = fr_q.locked && (fr_q.pos != '0);
                        fr_d.locked = 1'b1;
                        fr_d.pos    = POS_W'(1);
                    end else if (fr_q.locked) begin
                        take     = 1'b1;
                        last     = (fr_q.pos == POS_W'(TOP_LEN - 1));
                        fr_d.pos = last ? '0 : fr_q.pos + POS_W'(1);
                    end
                end
                default: begin
                    take     = 1'b1;
                    last     = (LEN_W'(fr_q.pos) == len_eff - LEN_W'(1));
                    fr_d.pos = last ? '0 : fr_q.pos + POS_W'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    // R1: a byte of a fixed-length trace never lands beyond the programmed length
    p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (mode == MODE_CYCLIC || mode == MODE_FIXED || mode == MODE_PERSIST))
            |-> (LEN_W'(pos) < len_eff));

    // R5: the top-bit frame never grows past its fixed size
    p_topbit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == MODE_TOPBIT) |-> (fr_q.pos < POS_W'(TOP_LEN)));

endmodule

// File: rtl/ptm_store.sv
module ptm_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             ref_we,
    input  logic [AW-1:0]    ref_addr,
    input  logic [7:0]       ref_wdata,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [AW-1:0]    cmp_addr,
    output logic [7:0]       ref_rdata,
    output logic [1:0][7:0]  bank_rdata,
    input  logic             host_bank,
    input  logic [AW-1:0]    host_addr,
    output logic [7:0]       host_rdata
);

    logic [7:0]      ref_mem [DEPTH];
    logic [1:0][7:0] host_word;

    always_ff @(posedge clk) begin
        if (ref_we) ref_mem[ref_addr] <= ref_wdata;
    end

    assign ref_rdata = ref_mem[cmp_addr];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
        end
        assign bank_rdata[b] = mem[cmp_addr];
        assign host_word[b]  = mem[host_addr];
    end

    assign host_rdata = host_word[host_bank];

endmodule

// File: rtl/path_trace_monitor.sv
module path_trace_monitor
    import ptm_pkg::*;
#(
    parameter int MAX_LEN  = 64,
    parameter int CRLF_LEN = 64,
    parameter int TOP_LEN  = 16,
    parameter int THR_W    = 3,
    localparam int POS_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [THR_W-1:0] cfg_persist,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             ref_we,
    input  logic [POS_W-1:0] ref_addr,
    input  logic [7:0]       ref_wdata,
    input  logic [POS_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             trace_end_o,
    output logic             mismatch_o,
    output logic             trace_valid_o
);

    typedef struct packed {
        logic             diff;
        logic             same;
        logic             mism;
        logic             acc_valid;
        logic             sel;
        logic             prev_in_acc;
        logic             have_prev;
        logic [THR_W-1:0] cnt;
        logic             done;
    } ctl_state_t;

    ctl_state_t       st_q, st_d;
    ptm_mode_e        mode;
    logic [LEN_W-1:0] len_eff;
    logic [THR_W-1:0] thr_eff;
    logic             persist;
    logic             take, last, bad, abort;
    logic [POS_W-1:0] pos;
    logic [7:0]       ref_rdata;
    logic [1:0][7:0]  bank_rdata;
    logic [7:0]       acc_byte, cap_byte, cmp_byte, prev_byte;
    logic             diff_now, same_now, accept;
    logic [THR_W-1:0] cnt_next;

    assign mode    = ptm_decode(cfg_mode);
    assign persist = (mode == MODE_PERSIST);
    assign len_eff = (cfg_len == '0) ? LEN_W'(1)
                   : (cfg_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cfg_len;
    assign thr_eff = (cfg_persist == '0) ? THR_W'(1) : cfg_persist;

    ptm_framer #(
        .MAX_LEN  (MAX_LEN),
        .CRLF_LEN (CRLF_LEN),
        .TOP_LEN  (TOP_LEN)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .len_eff  (len_eff),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .take     (take),
        .pos      (pos),
        .last     (last),
        .bad      (bad),
        .abort    (abort)
    );

    ptm_store #(
        .DEPTH (MAX_LEN),
        .AW    (POS_W)
    ) u_store (
        .clk        (clk),
        .ref_we     (ref_we),
        .ref_addr   (ref_addr),
        .ref_wdata  (ref_wdata),
        .wr_en      (take),
        .wr_bank    (persist ? ~st_q.sel : st_q.sel),
        .wr_addr    (pos),
        .wr_data    (in_byte),
        .cmp_addr   (pos),
        .ref_rdata  (ref_rdata),
        .bank_rdata (bank_rdata),
        .host_bank  (st_q.sel),
        .host_addr  (rd_addr),
        .host_rdata (rd_data)
    );

    always_comb begin
        acc_byte  = bank_rdata[st_q.sel];
        cap_byte  = bank_rdata[~st_q.sel];
        cmp_byte  = (mode == MODE_CYCLIC || persist) ? acc_byte : ref_rdata;
        prev_byte = st_q.prev_in_acc ? acc_byte : cap_byte;
        diff_now  = ((pos == '0) ? 1'b0 : st_q.diff) | (in_byte != cmp_byte);
        same_now  = ((pos == '0) ? 1'b1 : st_q.same) & (in_byte == prev_byte);
        cnt_next  = (st_q.have_prev && same_now)
                  ? ((st_q.cnt == '1) ? st_q.cnt : st_q.cnt + THR_W'(1))
                  : THR_W'(1);
        accept    = (cnt_next >= thr_eff);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (abort) begin
            st_d.done = 1'b1;
            st_d.mism = 1'b1;
        end
        if (take) begin
            st_d.diff = diff_now;
            st_d.same = same_now;
            if (last) begin
                st_d.done = 1'b1;
                if (persist) begin
                    st_d.cnt       = cnt_next;
                    st_d.have_prev = 1'b1;
                    if (accept) begin
                        st_d.sel         = ~st_q.sel;
                        st_d.prev_in_acc = 1'b1;
                        st_d.acc_valid   = 1'b1;
                        st_d.mism        = 1'b0;
                    end else begin
                        st_d.prev_in_acc = 1'b0;
                        if (st_q.acc_valid) st_d.mism = diff_now;
                    end
                end else begin
                    if (mode != MODE_CYCLIC || st_q.acc_valid) st_d.mism = diff_now | bad;
                    st_d.acc_valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trace_end_o   = st_q.done;
    assign mismatch_o    = st_q.mism;
    assign trace_valid_o = st_q.acc_valid;

    // R7: the flag moves only together with an end-of-trace pulse
    p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mismatch_o) |-> trace_end_o);

    // R10: an idle input cycle never produces an end-of-trace pulse
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !trace_end_o);

    // R6: once a stored trace exists it stays
    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trace_valid_o |=> trace_valid_o);

    // R2 and R6: without a stored reference the history-based modes never flag
    p_no_ref_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_CYCLIC || persist) && !trace_valid_o) |-> !mismatch_o);

endmodule

// File: tb/path_trace_monitor_tb.sv
module path_trace_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic [6:0] cfg_len = 7'd4;
    logic [2:0] cfg_persist = 3'd1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h0A;
    logic       ref_we = 1'b0;
    logic [5:0] ref_addr = '0;
    logic [7:0] ref_wdata = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       trace_end_o, mismatch_o, trace_valid_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    path_trace_monitor u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode), .cfg_len (cfg_len),
        .cfg_persist (cfg_persist), .in_valid (in_valid), .in_byte (in_byte),
        .ref_we (ref_we), .ref_addr (ref_addr), .ref_wdata (ref_wdata),
        .rd_addr (rd_addr), .rd_data (rd_data), .trace_end_o (trace_end_o),
        .mismatch_o (mismatch_o), .trace_valid_o (trace_valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'(32 + ((s * 7 + i * 3) % 90));
    endfunction

    function automatic logic [7:0] crlf_byte(input int i);
        if (i == 62) return 8'h0D;
        if (i == 63) return 8'h0A;
        return pat(9, i);
    endfunction

    function automatic logic [7:0] top_byte(input int i);
        return (i == 0) ? 8'hC1 : pat(5, i);
    endfunction

    task automatic do_reset(input int mode, input int len, input int thr);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_mode = 3'(mode); cfg_len = 7'(len); cfg_persist = 3'(thr);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'h0A;
    endtask

    task automatic wr_ref(input int a, input logic [7:0] d);
        @(negedge clk);
        ref_we = 1'b1; ref_addr = 6'(a); ref_wdata = d;
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    task automatic send_pat(input int s, input int n, input int alt, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = pat(s, i);
            if (i == alt) b = b ^ 8'h01;
            put(b);
            chk(req, trace_end_o, (i == n - 1) ? 1 : 0);
        end
    endtask

    task automatic rd_chk(input int s, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rd_addr = 6'(i);
            #1;
            chk(req, rd_data, pat(s, i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lens[6] = '{1, 2, 5, 64, 0, 100};
        int effs[6] = '{1, 2, 5, 64, 1, 64};

        // R9: reset state
        do_reset(0, 4, 1);
        chk("R9 end", trace_end_o, 0);
        chk("R9 mism", mismatch_o, 0);
        chk("R9 valid", trace_valid_o, 0);

        // R1, R2, R7, R8: cyclic mode over a sweep of lengths
        for (int k = 0; k < 6; k++) begin
            int e;
            e = effs[k];
            do_reset(0, lens[k], 1);
            send_pat(1, e, -1, "R1 end");
            chk("R2 first trace", mismatch_o, 0);
            chk("R2 valid", trace_valid_o, 1);
            send_pat(1, e, -1, "R1 end");
            chk("R2 repeat", mismatch_o, 0);
            send_pat(1, e, e - 1, "R1 end");
            chk("R7 set", mismatch_o, 1);
            send_pat(1, e, -1, "R1 end");
            chk("R2 vs altered", mismatch_o, 1);
            send_pat(1, e, -1, "R1 end");
            chk("R7 clear", mismatch_o, 0);
            rd_chk(1, e, "R8 cyclic");
        end

        // R2: unused code behaves as cyclic
        do_reset(6, 3, 1);
        send_pat(2, 3, -1, "R2 alias end");
        chk("R2 alias first", mismatch_o, 0);
        send_pat(3, 3, -1, "R2 alias end");
        chk("R2 alias diff", mismatch_o, 1);

        // R3, R10: fixed reference, every position corrupted once
        do_reset(1, 8, 1);
        for (int i = 0; i < 8; i++) wr_ref(i, pat(21, i));
        for (int p = 0; p < 8; p++) begin
            send_pat(21, 8, p, "R3 end");
            chk("R3 corrupt", mismatch_o, 1);
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                in_byte = 8'h0D;
                chk("R10 idle", trace_end_o, 0);
            end
            send_pat(21, 8, -1, "R3 end");
            chk("R3 match", mismatch_o, 0);
        end
        rd_chk(21, 8, "R8 fixed");

        // R4: CR/LF framing
        do_reset(2, 4, 1);
        for (int i = 0; i < 64; i++) wr_ref(i, crlf_byte(i));
        for (int i = 0; i < 10; i++) begin
            put(pat(3, i));
            chk("R4 unlocked", trace_end_o, 0);
        end
        put(8'h0D); chk("R4 align", trace_end_o, 0);
        put(8'h0A); chk("R4 align", trace_end_o, 0);
        for (int i = 0; i < 64; i++) begin
            put(crlf_byte(i));
            chk("R4 end", trace_end_o, (i == 63) ? 1 : 0);
        end
        chk("R4 good", mismatch_o, 0);
        for (int i = 0; i < 20; i++) begin
            put(crlf_byte(i));
            chk("R4 early end", trace_end_o, 0);
        end
        put(8'h0D); chk("R4 early end", trace_end_o, 0);
        put(8'h0A); chk("R4 early end", trace_end_o, 1);
        chk("R4 short", mismatch_o, 1);
        for (int i = 0; i < 64; i++) begin
            put(crlf_byte(i));
            chk("R4 end", trace_end_o, (i == 63) ? 1 : 0);
        end
        chk("R4 recover", mismatch_o, 0);

        // R5: top-bit framing with a restart inside a trace
        do_reset(3, 4, 1);
        for (int i = 0; i < 16; i++) wr_ref(i, top_byte(i));
        for (int i = 0; i < 6; i++) begin
            put(pat(2, i));
            chk("R5 unlocked", trace_end_o, 0);
        end
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 16; i++) begin
                put(top_byte(i));
                chk("R5 end", trace_end_o, (i == 15) ? 1 : 0);
            end
            chk("R5 good", mismatch_o, 0);
        end
        for (int i = 0; i < 5; i++) put(top_byte(i));
        put(top_byte(0));
        chk("R5 restart end", trace_end_o, 1);
        chk("R5 restart flag", mismatch_o, 1);
        for (int i = 1; i < 16; i++) begin
            put(top_byte(i));
            chk("R5 end", trace_end_o, (i == 15) ? 1 : 0);
        end
        chk("R5 after restart", mismatch_o, 0);

        // R6: persistence over every threshold setting
        for (int t = 0; t < 8; t++) begin
            int te;
            te = (t == 0) ? 1 : t;
            do_reset(4, 4, t);
            for (int k = 0; k < te - 1; k++) begin
                send_pat(11, 4, -1, "R6 end");
                chk("R6 not yet", trace_valid_o, 0);
                chk("R6 quiet", mismatch_o, 0);
            end
            send_pat(11, 4, -1, "R6 end");
            chk("R6 accept", trace_valid_o, 1);
            chk("R6 accept flag", mismatch_o, 0);
            rd_chk(11, 4, "R8 accepted");
            if (te >= 2) begin
                for (int k = 0; k < te - 1; k++) begin
                    send_pat(12, 4, -1, "R6 end");
                    chk("R6 new differs", mismatch_o, 1);
                end
                send_pat(13, 4, -1, "R6 end");
                chk("R6 break", mismatch_o, 1);
                for (int k = 0; k < te - 1; k++) begin
                    send_pat(12, 4, -1, "R6 end");
                    chk("R6 rebuild", mismatch_o, 1);
                end
                rd_chk(11, 4, "R8 held");
                send_pat(12, 4, -1, "R6 end");
                chk("R6 switch", mismatch_o, 0);
                rd_chk(12, 4, "R8 switched");
            end else begin
                send_pat(12, 4, -1, "R6 end");
                chk("R6 single", mismatch_o, 0);
                rd_chk(12, 4, "R8 single");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule